// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor read and write the registers of Ethernet PHYs over the two-wire management interface of IEEE 802.3 Clause 22. Software sees six 32-bit word registers on a simple write/read bus: a configuration word, a command word, a target address, a write-data word, a read-result word and a status indicator.

A write frame starts as soon as software stores a value into the write-data word. The frame uses the PHY and register numbers already held in the address word. A read frame starts when the read bit of the command word goes from 0 to 1. The block then derives the management clock (MDC) from the system clock and shifts out the frame. It releases the data pin for the turnaround and the 16 data bits of a read. When the read ends it places the returned value in the read-result word.

Two flags tell software when the block can take a new operation and when read data is ready. A reset bit in the configuration word aborts any frame in progress.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration word (word 0) reads 0x00000007. Word 1 (command), word 2 (address), word 3 (write data), word 4 (read result) and word 5 (indicator) all read 0.
- R2: The address word keeps only the PHY number in bits 12:8 and the register number in bits 4:0. Writing 0xFFFFFFFF to it reads back as 0x00001F1F.
- R3: A write to word 3 launches a write frame. The frame is 32 ones, start bits 01, opcode 01, the PHY number and the register number (each MSB first), turnaround 10, then bits 15:0 of the written value MSB first. The master drives all 64 bits.
- R4: A read frame launches only when a write to word 1 changes bit 0 from 0 to 1. Writing 1 while bit 0 is already 1 launches nothing.
- R5: A read frame carries opcode 10. The master drives only the first 46 bits. It releases the pin (output enable low) for the two turnaround bits and the 16 data bits. It samples the data bits on MDC rising edges and places them, first bit as bit 15, in bits 15:0 of word 4.
- R6: Indicator bit 0 (BUSY) is 1 from the cycle after a launch and stays 1 for exactly 128×H system clocks, H being the MDC half period.
- R7: Indicator bit 2 (NOTVALID) becomes 1 together with BUSY on a read launch. It returns to 0 in the same cycle that the read result is written. It is never 1 while BUSY is 0.
- R8: Configuration bits 2:0 (value D) set the MDC half period to H=(D+1)×4 system clocks. MDC is low while idle. Each bit cell is H clocks low, then H clocks high. The first rising edge comes H clocks after the launch.
- R9: A launch request (a write to word 3, or a rising edge of command bit 0) made while BUSY is 1 is ignored. The frame in progress is not altered and no frame follows it.
- R10: Word 4 keeps its value until the next read frame completes. Write frames leave it unchanged.
- R11: While configuration bit 31 is 1, the block aborts any frame, and one cycle later BUSY and NOTVALID are 0, MDC is low and the output enable is low. Launches are ignored while the bit is 1. Writing 0x00000007 restores normal operation with D=7.
- R12: The master changes its MDIO output only as MDC falls, never while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_word | input | 3 | Word index of the register (0 to 5) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
On every cycle, assertions check the following:
- MDC is low while idle and changes only on a divider tick.
- NOTVALID is set only while BUSY is set.
- The read result changes only when a read completes.
- The output is steady while MDC is high.
- A launch always raises BUSY, and the reset bit clears BUSY and the output enable.

The bench scenarios cover what those assertions cannot see. A behavioural PHY captures each frame bit by bit and answers reads with an address-derived pattern. The bench confirms the exact bit content of write and read frames, the BUSY length for two divider settings, and that requests made while busy or held in reset are ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_LEN    = 32;
  localparam int FRAME_BITS = PRE_LEN + 32;
  localparam int TA_IDX     = PRE_LEN + 14;
  localparam int DATA_IDX   = PRE_LEN + 16;
  localparam int AD_W       = 5;
  localparam int DW         = 16;

  localparam logic [2:0] W_CFG  = 3'd0;
  localparam logic [2:0] W_CMD  = 3'd1;
  localparam logic [2:0] W_ADR  = 3'd2;
  localparam logic [2:0] W_WDAT = 3'd3;
  localparam logic [2:0] W_RES  = 3'd4;
  localparam logic [2:0] W_IND  = 3'd5;

  typedef struct packed {
    logic            rd;
    logic [AD_W-1:0] phy;
    logic [AD_W-1:0] ra;
    logic [DW-1:0]   data;
  } mdio_req_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t q);
    logic [1:0] op;
    op = q.rd ? 2'b10 : 2'b01;
    return {{PRE_LEN{1'b1}}, 2'b01, op, q.phy, q.ra, 2'b10,
            (q.rd ? {DW{1'b1}} : q.data)};
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 3,
  parameter int MULT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int MAX_HALF = (2 ** DIV_W) * MULT;
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = CNT_W'((int'(div) + 1) * MULT - 1);
    tick  = en && (cnt_q == lim);
    cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: while enabled the count never runs past the half-period limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && $stable(div) |=> cnt_q <= lim);

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          start,
  input  mdio_req_t     req,
  input  logic          tick,
  input  logic          mdio_i,
  output logic          busy,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          done_rd,
  output logic [DW-1:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_I  = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DAT_I = IDX_W'(DATA_IDX);

  logic                  busy_q, busy_d, rd_q, rd_d, half_q, half_d, mdc_q, mdc_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [DW-1:0]         cap_q, cap_d;

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    half_d  = half_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    cap_d   = cap_q;
    mdc_d   = mdc_q;
    done_rd = 1'b0;
    if (srst) begin
      busy_d = 1'b0;
      half_d = 1'b0;
      idx_d  = '0;
      mdc_d  = 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        rd_d   = req.rd;
        half_d = 1'b0;
        idx_d  = '0;
        mdc_d  = 1'b0;
        sh_d   = build_frame(req);
      end
    end else if (tick) begin
      if (!half_q) begin
        half_d = 1'b1;
        mdc_d  = 1'b1;
        if (rd_q && idx_q >= DAT_I) cap_d = {cap_q[DW-2:0], mdio_i};
      end else begin
        half_d = 1'b0;
        mdc_d  = 1'b0;
        if (idx_q == LAST) begin
          busy_d  = 1'b0;
          done_rd = rd_q;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      half_q <= 1'b0;
      mdc_q  <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      half_q <= half_d;
      mdc_q  <= mdc_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && idx_q >= TA_I);
  assign rd_data = cap_q;

  // R8: MDC moves only on a divider tick or an abort
  p_mdc_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc_q) |-> $past(tick) || $past(srst));

  // R5: the read result is only ever handed over at the end of a read
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_rd |=> !busy_q);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  input  logic             done_rd,
  input  logic [DW-1:0]    rd_data,
  output logic             srst,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output mdio_req_t        req
);
  logic [31:0]     cfg_q, cfg_d, cmd_q, cmd_d;
  logic [AD_W-1:0] phy_q, phy_d, ra_q, ra_d;
  logic [DW-1:0]   wdat_q, wdat_d, res_q, res_d;
  logic            nv_q, nv_d;
  logic            we, go_wr, go_rd, accept;

  always_comb begin
    we     = bus_sel && bus_wr;
    go_wr  = we && (bus_word == W_WDAT);
    go_rd  = we && (bus_word == W_CMD) && bus_wdata[0] && !cmd_q[0];
    accept = !busy && !cfg_q[31];
    start  = accept && (go_wr || go_rd);

    req.rd   = go_rd;
    req.phy  = phy_q;
    req.ra   = ra_q;
    req.data = bus_wdata[DW-1:0];

    cfg_d  = (we && bus_word == W_CFG)  ? bus_wdata : cfg_q;
    cmd_d  = (we && bus_word == W_CMD)  ? bus_wdata : cmd_q;
    phy_d  = (we && bus_word == W_ADR)  ? bus_wdata[8 +: AD_W] : phy_q;
    ra_d   = (we && bus_word == W_ADR)  ? bus_wdata[0 +: AD_W] : ra_q;
    wdat_d = go_wr ? bus_wdata[DW-1:0] : wdat_q;
    res_d  = done_rd ? rd_data : res_q;

    nv_d = nv_q;
    if (cfg_q[31] || done_rd) nv_d = 1'b0;
    else if (accept && go_rd) nv_d = 1'b1;

    case (bus_word)
      W_CFG:   bus_rdata = cfg_q;
      W_CMD:   bus_rdata = cmd_q;
      W_ADR:   bus_rdata = {19'b0, phy_q, 3'b0, ra_q};
      W_WDAT:  bus_rdata = {16'b0, wdat_q};
      W_RES:   bus_rdata = {16'b0, res_q};
      W_IND:   bus_rdata = {29'b0, nv_q, 1'b0, busy};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 32'h0000_0007;
      cmd_q  <= '0;
      phy_q  <= '0;
      ra_q   <= '0;
      wdat_q <= '0;
      res_q  <= '0;
      nv_q   <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cmd_q  <= cmd_d;
      phy_q  <= phy_d;
      ra_q   <= ra_d;
      wdat_q <= wdat_d;
      res_q  <= res_d;
      nv_q   <= nv_d;
    end
  end

  assign srst = cfg_q[31];
  assign div  = cfg_q[DIV_W-1:0];

  // R7: NOTVALID only ever appears inside a busy frame
  p_nv_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_q |-> busy);

  // R10: the read result holds unless a read completes
  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_rd |=> $stable(res_q));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int MULT  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]       rs_q;
  logic             rst_s;
  logic             srst, start, tick, busy, done_rd;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    rd_data;
  mdio_req_t        req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  mdio_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_s), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done_rd(done_rd), .rd_data(rd_data),
    .srst(srst), .div(div), .start(start), .req(req)
  );

  mdio_clkdiv #(.DIV_W(DIV_W), .MULT(MULT)) div_i (
    .clk(clk), .rst_n(rst_s), .en(busy), .div(div), .tick(tick)
  );

  mdio_seq seq_i (
    .clk(clk), .rst_n(rst_s), .srst(srst), .start(start), .req(req),
    .tick(tick), .mdio_i(mdio_i), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_rd(done_rd), .rd_data(rd_data)
  );

  // R6: an accepted launch always raises BUSY
  p_busy_on_start_r6: assert property (@(posedge clk) disable iff (!rst_s)
    start |=> busy);

  // R8: MDC rests low while no frame is active
  p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !mdc);

  // R11: the reset bit empties the sequencer and frees the pin
  p_srst_idle_r11: assert property (@(posedge clk) disable iff (!rst_s)
    srst |=> !busy && !mdio_oe);

  // R12: output is steady across the MDC high phase
  p_hold_high_r12: assert property (@(posedge clk) disable iff (!rst_s)
    mdc && $past(mdc) |-> $stable(mdio_o));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk, rst_n, bus_sel, bus_wr;
  logic [2:0]  bus_word;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i, line;

  int checks = 0, failures = 0;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural PHY with pull-up on the shared line
  logic        phy_drv, phy_val, phy_rd;
  logic [15:0] phy_pat;
  logic [63:0] cap, oecap;
  int          phy_n;
  int          contend = 0, hold_err = 0;
  logic        mdc_prev = 1'b0, mo_prev = 1'b1;

  assign line   = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);
  assign mdio_i = line;

  function automatic logic [15:0] pat(input logic [4:0] p, input logic [4:0] r);
    return {p, ~r, 6'b101101};
  endfunction

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, (rd ? pat(p, r) : d)};
  endfunction

  function automatic logic [63:0] exp_oe(input logic rd);
    return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
  endfunction

  always @(posedge mdc) begin
    cap   <= {cap[62:0], line};
    oecap <= {oecap[62:0], mdio_oe};
    phy_n <= phy_n + 1;
  end

  always @(negedge mdc) begin
    if (phy_n == 46) begin
      phy_rd  = (cap[11:10] == 2'b10);
      phy_pat = pat(cap[9:5], cap[4:0]);
    end
    if (phy_rd && phy_n >= 47 && phy_n <= 63) begin
      phy_drv = 1'b1;
      phy_val = (phy_n == 47) ? 1'b0 : phy_pat[63-phy_n];
    end else begin
      phy_drv = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (mdio_oe && phy_drv) contend++;
    if (mdc && mdc_prev && mdio_o !== mo_prev) hold_err++;
    mdc_prev = mdc;
    mo_prev  = mdio_o;
  end

  task automatic phy_clear();
    phy_n   = 0;
    phy_drv = 1'b0;
    phy_rd  = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] v);
    bus_word = w;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(3'd5, v);
    while (v[0] && n < 20000) begin
      n++;
      @(negedge clk);
      rd(3'd5, v);
    end
  endtask

  // {rd, phy, reg, data}
  localparam logic [26:0] VEC [0:5] = '{
    {1'b0, 5'h01, 5'h00, 16'h1234},
    {1'b1, 5'h01, 5'h02, 16'h0000},
    {1'b0, 5'h1F, 5'h1F, 16'hFFFF},
    {1'b1, 5'h00, 5'h00, 16'h0000},
    {1'b0, 5'h0A, 5'h15, 16'h0000},
    {1'b1, 5'h1F, 5'h1F, 16'h0000}
  };

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, hi, first;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_word = '0; bus_wdata = '0;
    phy_clear();
    cap = '0; oecap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int w = 0; w < 6; w++) begin
      rd(3'(w), v);
      chk($sformatf("R1 word%0d", w), 64'(v), (w == 0) ? 64'h7 : 64'h0);
    end
    chk("R8 mdc idle low", 64'(mdc), 64'h0);

    // R2 address field positions
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v);
    chk("R2 addr readback", 64'(v), 64'h1F1F);

    wr(3'd0, 32'h0);  // H = 4

    for (int i = 0; i < 6; i++) begin
      logic r; logic [4:0] p, a; logic [15:0] d;
      {r, p, a, d} = VEC[i];
      wr(3'd2, {19'b0, p, 3'b0, a});
      phy_clear();
      if (r) begin
        wr(3'd1, 32'h0);
        wr(3'd1, 32'h1);
      end else begin
        wr(3'd3, {16'hDEAD, d});
      end
      rd(3'd5, v);
      chk($sformatf("R6 busy after launch v%0d", i), 64'(v[0]), 64'h1);
      chk($sformatf("R7 notvalid at launch v%0d", i), 64'(v[2]), 64'(r));
      wait_idle(n);
      chk($sformatf("R6 busy length v%0d", i), 64'(n), 64'd512);
      chk($sformatf("%s frame v%0d", r ? "R5" : "R3", i), cap, exp_frame(r, p, a, d));
      chk($sformatf("R5 oe pattern v%0d", i), oecap, exp_oe(r));
      rd(3'd5, v);
      chk($sformatf("R7 notvalid cleared v%0d", i), 64'(v[2]), 64'h0);
      if (r) begin
        rd(3'd4, v);
        chk($sformatf("R5 read result v%0d", i), 64'(v), 64'(pat(p, a)));
      end
    end

    // R4 writing 1 again does not relaunch
    wr(3'd1, 32'h1);
    rd(3'd5, v);
    chk("R4 no relaunch", 64'(v), 64'h0);

    // R9 requests while busy ignored
    wr(3'd2, {19'b0, 5'h06, 3'b0, 5'h09});
    phy_clear();
    wr(3'd3, 32'h0000_C3A5);
    repeat (100) @(negedge clk);
    wr(3'd3, 32'h0000_0F0F);
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h1);
    wait_idle(n);
    chk("R9 frame unchanged", cap, exp_frame(1'b0, 5'h06, 5'h09, 16'hC3A5));
    repeat (50) @(negedge clk);
    rd(3'd5, v);
    chk("R9 no follow-on frame", 64'(v), 64'h0);
    chk("R9 cell count", 64'(phy_n), 64'd64);
    rd(3'd4, v);
    chk("R10 result held across write", 64'(v), 64'(pat(5'h1F, 5'h1F)));

    // R8 divider with D=1 (H=8)
    wr(3'd0, 32'h1);
    wr(3'd2, {19'b0, 5'h02, 3'b0, 5'h03});
    phy_clear();
    wr(3'd3, 32'h0000_5A5A);
    n = 0; hi = 0; first = -1;
    rd(3'd5, v);
    while (v[0] && n < 20000) begin
      if (mdc && first < 0) first = n;
      if (mdc) hi++;
      n++;
      @(negedge clk);
      rd(3'd5, v);
    end
    chk("R8 first rise", 64'(first), 64'd8);
    chk("R8 high clocks", 64'(hi), 64'd512);
    chk("R6 busy length H8", 64'(n), 64'd1024);
    chk("R3 frame H8", cap, exp_frame(1'b0, 5'h02, 5'h03, 16'h5A5A));

    // R11 abort with the reset bit
    wr(3'd0, 32'h0);
    wr(3'd2, {19'b0, 5'h03, 3'b0, 5'h07});
    phy_clear();
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h1);
    repeat (200) @(negedge clk);
    wr(3'd0, 32'h8000_0000);
    @(negedge clk);
    rd(3'd5, v);
    chk("R11 busy/notvalid cleared", 64'(v), 64'h0);
    chk("R11 mdc low", 64'(mdc), 64'h0);
    chk("R11 oe low", 64'(mdio_oe), 64'h0);
    wr(3'd3, 32'h0000_AAAA);
    rd(3'd5, v);
    chk("R11 launch ignored in reset", 64'(v), 64'h0);
    wr(3'd0, 32'h7);
    rd(3'd0, v);
    chk("R11 release value", 64'(v), 64'h7);
    phy_clear();
    wr(3'd1, 32'h0);
    wr(3'd1, 32'h1);
    wait_idle(n);
    chk("R11 busy length D7", 64'(n), 64'd4096);
    rd(3'd4, v);
    chk("R11 read after release", 64'(v), 64'(pat(5'h03, 5'h07)));
    chk("R5 frame after release", cap, exp_frame(1'b1, 5'h03, 5'h07, 16'h0));

    chk("R5 no pin contention", 64'(contend), 64'h0);
    chk("R12 output steady while mdc high", 64'(hold_err), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule